// File: doc/BRIEF.md
# Transport Stream PID Filter Bank

This block sits on the receive path of a digital broadcast front end and decides which 188-byte transport stream packets reach the host. Packets arrive one byte per accepted cycle, with a marker on the first byte. The block reads the 13-bit packet identifier from the header. It compares that identifier with a bank of programmable slots and forwards the packets it keeps as 32-bit words.

Software programs the slots through a simple 32-bit register port. Each slot holds an identifier and an enable bit. Slot 0 also carries three global mode bits: forward every packet, suppress all output, and the byte order of the output words. The first three header bytes are held until the keep decision is made, so a forwarded packet leaves whole and in order. A packet whose first byte is not the sync value is discarded.

Top module: `ts_pid_filter_bank`

## Requirements
- R1: Slot n sits at byte address 4*n, and address bits [4:2] select the slot. A read returns the slot's identifier in bits 12:0 and its enable in bit 15. For slot 0 only, the read also returns suppress-all in bit 13, byte order in bit 14 and forward-all in bit 16. Every other bit reads 0, whatever was written to it.
- R2: After reset every slot holds identifier 0x1FFF with its enable clear, and suppress-all is set, so slot 0 reads 0x00003FFF and the other slots read 0x00001FFF. No word is output until the registers are written.
- R3: With both global modes clear, a packet is forwarded only if some enabled slot holds its identifier. The identifier is bits 4:0 of header byte 1 followed by all of header byte 2; the top three bits of byte 1 are ignored. A slot that matches but is not enabled has no effect.
- R4: With forward-all set and suppress-all clear, every packet that has a valid sync byte is forwarded, whatever the slots hold.
- R5: While suppress-all is set, no packet is forwarded. It overrides both forward-all and slot matches.
- R6: A packet whose first byte is not 0x47 produces no output, even with forward-all set.
- R7: A forwarded packet leaves as 47 words. When bit 14 is 0, the earliest byte is in bits 31:24; when it is 1, the earliest byte is in bits 7:0. The first word carries the start flag and the 47th carries the end flag. Each word appears one cycle after its fourth byte is accepted.
- R8: Input cycles with the valid input low are ignored, whatever the data and start inputs hold. Valid bytes that arrive outside a packet, without a start marker, are ignored.
- R9: A start marker in the middle of a packet abandons that packet. The new packet is filtered on its own header only.
- R10: The decision for a packet uses the settings in force when its third byte is accepted. A register write after that point does not change how that packet is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for the addressed register (combinational) |
| in_valid_i | input | 1 | Input byte valid |
| in_sop_i | input | 1 | Input byte is the first byte of a packet |
| in_data_i | input | 8 | Input byte |
| out_valid_o | output | 1 | Output word valid |
| out_sop_o | output | 1 | First word of a forwarded packet |
| out_eop_o | output | 1 | Last word of a forwarded packet |
| out_data_o | output | 32 | Output word |

## Verification
The hardest case to reach from the ports is a register write that lands while a packet is in flight, after its keep decision has been made. The bench's packet driver can issue a write to slot 0 on a chosen byte of a packet. This sets suppress-all in the middle of a packet that forward-all has already kept. An abandoned packet is reached the same way: the driver stops after a chosen byte count and the next start marker arrives while the framer still counts the old packet.

// File: rtl/ts_filt_pkg.sv
`timescale 1ns/1ps
package ts_filt_pkg;
  localparam int unsigned PID_W    = 13;
  localparam int unsigned BIT_BLK  = 13;
  localparam int unsigned BIT_LE   = 14;
  localparam int unsigned BIT_EN   = 15;
  localparam int unsigned BIT_PASS = 16;
  localparam logic [7:0]  SYNC_B   = 8'h47;
  localparam logic [PID_W-1:0] PID_PARK = 13'h1FFF;
endpackage

// File: rtl/ts_filt_regs.sv
`timescale 1ns/1ps
module ts_filt_regs
  import ts_filt_pkg::*;
#(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned SLOT_W  = $clog2(N_SLOTS),
  parameter int unsigned ADDR_W  = SLOT_W + 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [31:0]                     wdata_i,
  output logic [31:0]                     rdata_o,
  output logic [N_SLOTS-1:0][PID_W-1:0]   slot_pid_o,
  output logic [N_SLOTS-1:0]              slot_en_o,
  output logic                            blk_o,
  output logic                            le_o,
  output logic                            pass_o
);
  logic [SLOT_W-1:0] sel;
  assign sel = addr_i[ADDR_W-1:2];

  logic unused_bits;
  assign unused_bits = ^{wdata_i[31:17], addr_i[1:0]};

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_pid_o[g] <= PID_PARK;
        slot_en_o[g]  <= 1'b0;
      end else if (we_i && sel == SLOT_W'(g)) begin
        slot_pid_o[g] <= wdata_i[PID_W-1:0];
        slot_en_o[g]  <= wdata_i[BIT_EN];
      end
    end
  end

  // global modes live in slot 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_o  <= 1'b1;
      le_o   <= 1'b0;
      pass_o <= 1'b0;
    end else if (we_i && sel == '0) begin
      blk_o  <= wdata_i[BIT_BLK];
      le_o   <= wdata_i[BIT_LE];
      pass_o <= wdata_i[BIT_PASS];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (sel == SLOT_W'(i)) begin
        rdata_o[PID_W-1:0] = slot_pid_o[i];
        rdata_o[BIT_EN]    = slot_en_o[i];
      end
    end
    if (sel == '0) begin
      rdata_o[BIT_BLK]  = blk_o;
      rdata_o[BIT_LE]   = le_o;
      rdata_o[BIT_PASS] = pass_o;
    end
  end
endmodule

// File: rtl/ts_pid_match.sv
`timescale 1ns/1ps
module ts_pid_match
  import ts_filt_pkg::*;
#(
  parameter int unsigned N_SLOTS = 8
) (
  input  logic [PID_W-1:0]              pid_i,
  input  logic [N_SLOTS-1:0][PID_W-1:0] slot_pid_i,
  input  logic [N_SLOTS-1:0]            slot_en_i,
  input  logic                          blk_i,
  input  logic                          pass_i,
  output logic                          keep_o
);
  logic [N_SLOTS-1:0] hit;

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
    assign hit[g] = slot_en_i[g] && (slot_pid_i[g] == pid_i);
  end

  // suppress beats forward-all, forward-all beats slot hits
  assign keep_o = !blk_i && (pass_i || (|hit));
endmodule

// File: rtl/ts_pkt_framer.sv
`timescale 1ns/1ps
module ts_pkt_framer
  import ts_filt_pkg::*;
#(
  parameter int unsigned PKT_LEN = 188,
  parameter int unsigned IDX_W   = $clog2(PKT_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic [7:0]        in_data_i,
  input  logic              keep_i,
  input  logic              le_i,
  output logic [PID_W-1:0]  pid_o,
  output logic              dec_o,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [31:0]       out_data_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_LEN - 1);
  localparam logic [IDX_W-1:0] FIRST_W  = IDX_W'(3);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic             keep_q;
  logic             le_q;
  logic [23:0]      hold_q;   // last three bytes, newest in [7:0]

  assign pid_o = {hold_q[PID_W-9:0], in_data_i};
  assign dec_o = in_valid_i && !in_sop_i && active_q && (idx_q == IDX_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      idx_q       <= '0;
      keep_q      <= 1'b0;
      le_q        <= 1'b0;
      hold_q      <= '0;
      out_valid_o <= 1'b0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      out_sop_o   <= 1'b0;
      out_eop_o   <= 1'b0;
      if (in_valid_i) begin
        if (in_sop_i) begin
          active_q <= (in_data_i == SYNC_B);
          idx_q    <= IDX_W'(1);
          keep_q   <= 1'b0;
          hold_q   <= {hold_q[15:0], in_data_i};
        end else if (active_q) begin
          hold_q <= {hold_q[15:0], in_data_i};
          idx_q  <= idx_q + 1'b1;
          if (dec_o) begin
            keep_q <= keep_i;
            le_q   <= le_i;
          end
          if (idx_q[1:0] == 2'd3 && keep_q) begin
            out_valid_o <= 1'b1;
            out_sop_o   <= (idx_q == FIRST_W);
            out_eop_o   <= (idx_q == LAST_IDX);
            out_data_o  <= le_q ? {in_data_i, hold_q[7:0], hold_q[15:8], hold_q[23:16]}
                                : {hold_q, in_data_i};
          end
          if (idx_q == LAST_IDX) active_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ts_pid_filter_bank.sv
`timescale 1ns/1ps
module ts_pid_filter_bank
  import ts_filt_pkg::*;
#(
  parameter int unsigned N_SLOTS = 8,
  parameter int unsigned PKT_LEN = 188,
  localparam int unsigned SLOT_W = $clog2(N_SLOTS),
  localparam int unsigned ADDR_W = SLOT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic [7:0]        in_data_i,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [31:0]       out_data_o
);
  localparam int unsigned IDX_W = $clog2(PKT_LEN);

  logic [N_SLOTS-1:0][PID_W-1:0] slot_pid;
  logic [N_SLOTS-1:0]            slot_en;
  logic                          cfg_blk, cfg_le, cfg_pass;
  logic [PID_W-1:0]              hdr_pid;
  logic                          dec_stb, keep;

  ts_filt_regs #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .slot_pid_o (slot_pid),
    .slot_en_o  (slot_en),
    .blk_o      (cfg_blk),
    .le_o       (cfg_le),
    .pass_o     (cfg_pass)
  );

  ts_pid_match #(.N_SLOTS(N_SLOTS)) match_i (
    .pid_i      (hdr_pid),
    .slot_pid_i (slot_pid),
    .slot_en_i  (slot_en),
    .blk_i      (cfg_blk),
    .pass_i     (cfg_pass),
    .keep_o     (keep)
  );

  ts_pkt_framer #(.PKT_LEN(PKT_LEN), .IDX_W(IDX_W)) framer_i (
    .clk_i, .rst_ni,
    .in_valid_i, .in_sop_i, .in_data_i,
    .keep_i     (keep),
    .le_i       (cfg_le),
    .pid_o      (hdr_pid),
    .dec_o      (dec_stb),
    .out_valid_o, .out_sop_o, .out_eop_o, .out_data_o
  );
endmodule

// File: rtl/ts_pid_filter_bank_chk.sv
`timescale 1ns/1ps
module ts_pid_filter_bank_chk #(
  parameter int unsigned PKT_LEN = 188
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic        in_valid_i,
  input logic        in_sop_i,
  input logic        out_valid_o,
  input logic        out_sop_o,
  input logic        out_eop_o,
  input logic [31:0] out_data_o,
  input logic        dec_stb,
  input logic        cfg_blk
);
  localparam int unsigned WORDS = PKT_LEN / 4;
  localparam int unsigned CW    = $clog2(WORDS + 1);

  logic          written_q, blocked_q;
  logic [CW-1:0] wcnt_q;
  logic          unused_mid;
  assign unused_mid = ^out_data_o[23:8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      written_q <= 1'b0;
      blocked_q <= 1'b0;
      wcnt_q    <= '0;
    end else begin
      if (reg_we_i) written_q <= 1'b1;
      if (in_valid_i && in_sop_i) blocked_q <= 1'b0;
      else if (dec_stb && cfg_blk) blocked_q <= 1'b1;
      if (out_valid_o) wcnt_q <= out_sop_o ? CW'(1) : wcnt_q + 1'b1;
    end
  end

  assert_sop_marks_word_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_sop_o || out_eop_o) |-> out_valid_o);
  assert_eop_at_word_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_eop_o |-> (wcnt_q == CW'(WORDS - 1)));
  assert_head_has_sync_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sop_o |-> (out_data_o[31:24] == 8'h47 || out_data_o[7:0] == 8'h47));
  assert_quiet_until_config_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !written_q |-> !out_valid_o);
  assert_suppressed_packet_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_q |-> !out_valid_o);
endmodule

bind ts_pid_filter_bank ts_pid_filter_bank_chk #(.PKT_LEN(PKT_LEN)) chk_i (
  .clk_i, .rst_ni, .reg_we_i, .in_valid_i, .in_sop_i,
  .out_valid_o, .out_sop_o, .out_eop_o, .out_data_o,
  .dec_stb, .cfg_blk
);

// File: tb/ts_pid_filter_bank_tb_top.sv
`timescale 1ns/1ps
module ts_pid_filter_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        in_valid = 1'b0, in_sop = 1'b0;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_sop, out_eop;
  logic [31:0] out_data;

  int tests = 0, fails = 0;
  int cyc = 0, b3_cyc = 0, first_cyc = -1;
  logic [31:0] rx_w [64];
  bit          rx_s [64], rx_e [64];
  int          rx_n = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ts_pid_filter_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .in_valid_i(in_valid), .in_sop_i(in_sop), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_sop_o(out_sop), .out_eop_o(out_eop), .out_data_o(out_data)
  );

  always @(negedge clk) begin
    if (out_valid && rx_n < 64) begin
      if (rx_n == 0) first_cyc = cyc;
      rx_w[rx_n] = out_data;
      rx_s[rx_n] = out_sop;
      rx_e[rx_n] = out_eop;
      rx_n = rx_n + 1;
    end
  end

  typedef struct packed {
    logic [31:0] r0;
    logic [2:0]  slot;
    logic [31:0] rs;
    logic [12:0] pid;
    logic        pass;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h0000_1FFF, 3'd3, 32'h0000_8100, 13'h0100, 1'b1, 4'd3}, // R3 enabled match
    '{32'h0000_1FFF, 3'd3, 32'h0000_8100, 13'h0101, 1'b0, 4'd3}, // R3 miss
    '{32'h0000_1FFF, 3'd3, 32'h0000_0100, 13'h0100, 1'b0, 4'd3}, // R3 disabled slot
    '{32'h0001_1FFF, 3'd3, 32'h0000_0100, 13'h0ABC, 1'b1, 4'd4}, // R4 forward-all
    '{32'h0001_3FFF, 3'd3, 32'h0000_0100, 13'h0ABC, 1'b0, 4'd5}, // R5 over forward-all
    '{32'h0000_A055, 3'd1, 32'h0000_1FFF, 13'h0055, 1'b0, 4'd5}, // R5 over slot hit
    '{32'h0000_C055, 3'd1, 32'h0000_1FFF, 13'h0055, 1'b1, 4'd7}, // R7 low-first order
    '{32'h0000_1FFF, 3'd7, 32'h0000_9FFF, 13'h1FFF, 1'b1, 4'd3}  // R3 top slot
  };

  function automatic string tag(int r);
    case (r)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] eb(int i, logic [7:0] sync, logic [12:0] pid, logic [7:0] seed);
    if (i == 0) return sync;
    if (i == 1) return {3'b101, pid[12:8]};
    if (i == 2) return pid[7:0];
    return 8'(i * 7) ^ seed;
  endfunction

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(logic [4:0] a, logic [31:0] exp, string req);
    @(negedge clk); addr = a; #1;
    chk(rdata == exp, req, rdata, exp);
  endtask

  task automatic stray(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); in_valid = 1'b1; in_sop = 1'b0; in_data = 8'h47;
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic send_pkt(logic [7:0] sync, logic [12:0] pid, logic [7:0] seed, int nb,
                          bit gap, bit mid_wr, logic [31:0] mid_val);
    rx_n = 0; first_cyc = -1;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_data = eb(i, sync, pid, seed);
      if (i == 3) b3_cyc = cyc;
      if (mid_wr && i == 20) begin we = 1'b1; addr = '0; wdata = mid_val; end
      else we = 1'b0;
      if (gap && (i % 5 == 2)) begin
        @(negedge clk); we = 1'b0;
        in_valid = 1'b0; in_sop = 1'b1; in_data = 8'h47;
      end
    end
    @(negedge clk); in_valid = 1'b0; in_sop = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_pkt(bit pass, bit le, logic [12:0] pid, logic [7:0] seed, string req);
    int bad = 0;
    chk(rx_n == (pass ? 47 : 0), req, rx_n, pass ? 47 : 0);
    if (pass && rx_n == 47) begin
      for (int w = 0; w < 47; w++) begin
        logic [31:0] e;
        e = le ? {eb(4*w+3, 8'h47, pid, seed), eb(4*w+2, 8'h47, pid, seed),
                  eb(4*w+1, 8'h47, pid, seed), eb(4*w, 8'h47, pid, seed)}
               : {eb(4*w, 8'h47, pid, seed), eb(4*w+1, 8'h47, pid, seed),
                  eb(4*w+2, 8'h47, pid, seed), eb(4*w+3, 8'h47, pid, seed)};
        if (rx_w[w] !== e || rx_s[w] != (w == 0) || rx_e[w] != (w == 46)) bad++;
      end
      chk(bad == 0, req, bad, 0);
    end
  endtask

  initial begin
    #500_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    rd_chk(5'h00, 32'h0000_3FFF, "R2");
    rd_chk(5'h14, 32'h0000_1FFF, "R2");
    send_pkt(8'h47, 13'h1FFF, 8'h11, 188, 0, 0, 0);
    chk(rx_n == 0, "R2", rx_n, 0);

    // R1 field layout
    wr(5'h08, 32'hFFFF_FFFF);
    rd_chk(5'h08, 32'h0000_9FFF, "R1");
    wr(5'h00, 32'hFFFF_FFFF);
    rd_chk(5'h00, 32'h0001_FFFF, "R1");
    wr(5'h08, 32'h0000_1FFF);
    rd_chk(5'h08, 32'h0000_1FFF, "R1");

    for (int i = 0; i < 8; i++) begin
      wr(5'h00, VECS[i].r0);
      wr({VECS[i].slot, 2'b00}, VECS[i].rs);
      send_pkt(8'h47, VECS[i].pid, 8'(i * 13), 188, 0, 0, 0);
      check_pkt(VECS[i].pass, VECS[i].r0[14], VECS[i].pid, 8'(i * 13), tag(int'(VECS[i].req)));
    end
    wr(5'h1C, 32'h0000_1FFF);

    // R7 latency and high-first order
    wr(5'h00, 32'h0001_1FFF);
    send_pkt(8'h47, 13'h0777, 8'h5A, 188, 0, 0, 0);
    check_pkt(1, 0, 13'h0777, 8'h5A, "R7");
    chk(first_cyc == b3_cyc + 1, "R7", first_cyc, b3_cyc + 1);

    // R6 bad sync, forward-all on
    send_pkt(8'h46, 13'h0777, 8'h5A, 188, 0, 0, 0);
    chk(rx_n == 0, "R6", rx_n, 0);

    // R8 idle cycles and stray bytes
    stray(4);
    send_pkt(8'h47, 13'h0321, 8'hC3, 188, 1, 0, 0);
    check_pkt(1, 0, 13'h0321, 8'hC3, "R8");

    // R9 abandoned packets
    wr(5'h00, 32'h0000_1FFF);
    wr(5'h0C, 32'h0000_8100);
    send_pkt(8'h47, 13'h0200, 8'h01, 60, 0, 0, 0);
    chk(rx_n == 0, "R9", rx_n, 0);
    send_pkt(8'h47, 13'h0100, 8'h02, 188, 0, 0, 0);
    check_pkt(1, 0, 13'h0100, 8'h02, "R9");
    send_pkt(8'h47, 13'h0100, 8'h03, 60, 0, 0, 0);
    chk(rx_n == 15, "R9", rx_n, 15);
    send_pkt(8'h47, 13'h0200, 8'h04, 188, 0, 0, 0);
    chk(rx_n == 0, "R9", rx_n, 0);

    // R10 write after the decision
    wr(5'h00, 32'h0001_1FFF);
    send_pkt(8'h47, 13'h0AAA, 8'h77, 188, 0, 1, 32'h0001_3FFF);
    check_pkt(1, 0, 13'h0AAA, 8'h77, "R10");
    send_pkt(8'h47, 13'h0AAA, 8'h78, 188, 0, 0, 0);
    chk(rx_n == 0, "R10", rx_n, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule